// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor core. Each line that rises sets a sticky pending flag for its source. Software programs a per-source enable bit and a three-level-bit priority through a small word-addressed register port. On every cycle the controller picks one winner among the sources that are both pending and enabled: the lowest priority value, which is the most urgent, and among equals the lowest source number. It offers that winner to the core as a request strobe plus a source number.

The controller also keeps a stack of active handler priorities. A winner is offered only when no handler is running, or when its priority value is strictly below that of the running handler. Requests of equal or lower urgency wait. When the core reports entry to a handler, the offered source's pending flag is cleared and its level is pushed. When the core reports an exit, the previous level comes back. Because the winner is worked out again every cycle, two cases need no extra logic. A more urgent arrival before the core reports entry replaces the offered source. A pending request can be offered again right after an exit, without the core first returning to thread level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no source is pending or enabled, every priority is 0, `irq_req` is low and `act_valid` is low.
- R2: Priority word `16 + s/4` holds source `s` in byte `s%4`. Only bits [7:5] of each byte are stored, and bits [4:0] of each byte read back as 0.
- R3: Enable word `s/32` holds source `s` in bit `s%32`. Bits for sources at or above `N_SRC` read as 0, and any address that maps neither an enable word nor a priority word reads as 0.
- R4: A rising edge on `irq_in[s]` sets the pending flag of source `s`. The flag stays set until entry to that source's handler is taken. A pending source that is disabled is never offered, but it is offered once it is enabled.
- R5: Among the sources that are pending and enabled, the lowest priority value wins. Among equal values, the lowest source number wins.
- R6: With no active handler, any winner is offered. With an active handler, the winner is offered only if its priority value is strictly less than `act_prio`. Equal or larger values are held pending.
- R7: When `core_enter` is high while `irq_req` is high (and `core_exit` is low), the offered source's level is pushed and becomes `act_prio`, and its pending flag is cleared. When `core_enter` is high while `irq_req` is low, it has no effect.
- R8: `core_exit` pops the active stack, so the preempted level is again reported. When the stack is empty, `act_valid` is low, and an exit then has no effect.
- R9: If a more urgent source becomes pending before the core reports entry, the entry taken is that of the source offered in the entry cycle.
- R10: In the cycle after an exit, `irq_req` and `irq_num` already reflect the next eligible pending source, judged against the restored level.
- R11: When `core_enter` and `core_exit` are high in the same cycle, only the exit is applied, and the offered source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Peripheral request lines, rising edge sets pending |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| core_enter | input | 1 | Core takes the offered handler |
| core_exit | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | A source may be entered now |
| irq_num | output | $clog2(N_SRC) | Offered source number |
| act_valid | output | 1 | A handler is active |
| act_prio | output | 3 | Priority of the innermost active handler |

## Verification
The bound checker checks, on every cycle, that an offered source is pending and enabled and is strictly more urgent than any active level. It also checks that an accepted entry pushes the winner's level and clears that source's pending flag, and that a stray entry or an exit at empty leaves the active state alone. Only the directed scenarios can show the ordering behaviour as a whole: tie-breaks by source number, a nested preemption unwinding back to the preempted level, a late urgent arrival displacing the offered source, tail-chained service of held requests, and the register address map with its masked read-back.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W    = 3;
    localparam int LEVELS    = 1 << PRIO_W;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 5;
    localparam int PRIO_BASE = 16;
    localparam int SRC_PER_P = REG_W / 8;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N_SRC = 40,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             clr_valid,
    input  logic [IW-1:0]    clr_idx,
    output logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] rise
);
    typedef struct packed {
        logic [N_SRC-1:0] line;
        logic [N_SRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        logic [N_SRC-1:0] clr_mask;
        clr_mask = '0;
        if (clr_valid) clr_mask[clr_idx] = 1'b1;
        rise      = irq_in & ~st_q.line;
        st_d.line = irq_in;
        // a fresh edge in the acknowledge cycle keeps the flag set
        st_d.pend = (st_q.pend & ~clr_mask) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
    import irq_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [REG_W-1:0]             cfg_wdata,
    output logic [REG_W-1:0]             cfg_rdata,
    output logic [N_SRC-1:0]             en_q,
    output logic [N_SRC-1:0][PRIO_W-1:0] prio_q
);
    typedef struct packed {
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (cfg_addr == ADDR_W'(s / REG_W))
                    st_d.en[s] = cfg_wdata[s % REG_W];
                if (cfg_addr == ADDR_W'(PRIO_BASE + s / SRC_PER_P))
                    st_d.prio[s] = cfg_wdata[8*(s % SRC_PER_P) + 8 - PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (cfg_addr == ADDR_W'(s / REG_W))
                cfg_rdata[s % REG_W] = st_q.en[s];
            if (cfg_addr == ADDR_W'(PRIO_BASE + s / SRC_PER_P))
                cfg_rdata[8*(s % SRC_PER_P) + 8 - PRIO_W +: PRIO_W] = st_q.prio[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign prio_q = st_q.prio;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int N_SRC = 40,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             pend,
    input  logic [N_SRC-1:0]             en,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         win_valid,
    output logic [IW-1:0]                win_idx,
    output prio_t                        win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = prio_t'(LEVELS - 1);
        // ascending scan with strict compare keeps the lowest index on ties
        for (int s = 0; s < N_SRC; s++) begin
            if (pend[s] && en[s] && (!win_valid || prio[s] < win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IW'(s);
                win_prio  = prio[s];
            end
        end
    end
endmodule

// File: rtl/irq_stack.sv
module irq_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = LEVELS,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int XW   = $clog2(DEPTH)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  prio_t push_prio,
    input  logic  pop,
    output logic  act_valid,
    output prio_t act_prio
);
    typedef struct packed {
        logic [CW-1:0]            cnt;
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        end else if (push && st_q.cnt < CW'(DEPTH)) begin
            st_d.ent[XW'(st_q.cnt)] = push_prio;
            st_d.cnt                = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_valid = (st_q.cnt != '0);
    assign act_prio  = act_valid ? st_q.ent[XW'(st_q.cnt - CW'(1))] : '0;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 40,
    localparam int IW   = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    irq_in,
    input  logic                cfg_wr,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                core_enter,
    input  logic                core_exit,
    output logic                irq_req,
    output logic [IW-1:0]       irq_num,
    output logic                act_valid,
    output logic [PRIO_W-1:0]   act_prio
);
    logic [N_SRC-1:0]             pend_q;
    logic [N_SRC-1:0]             rise;
    logic [N_SRC-1:0]             en_q;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
    logic                         win_valid;
    logic [IW-1:0]                win_idx;
    prio_t                        win_prio;
    logic                         accept;

    irq_cfg #(.N_SRC(N_SRC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en_q(en_q), .prio_q(prio_q)
    );

    irq_pend #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_valid(accept),
        .clr_idx(win_idx), .pend_q(pend_q), .rise(rise)
    );

    irq_arb #(.N_SRC(N_SRC)) u_arb (
        .pend(pend_q), .en(en_q), .prio(prio_q),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    irq_stack #(.DEPTH(LEVELS)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_prio(win_prio),
        .pop(core_exit), .act_valid(act_valid), .act_prio(act_prio)
    );

    assign irq_req = win_valid && (!act_valid || win_prio < act_prio);
    assign irq_num = win_idx;
    assign accept  = core_enter && !core_exit && irq_req;
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk
    import irq_pkg::*;
#(
    parameter int N_SRC = 40,
    localparam int IW   = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_enter,
    input logic             core_exit,
    input logic             irq_req,
    input logic [IW-1:0]    irq_num,
    input logic             act_valid,
    input logic [PRIO_W-1:0] act_prio,
    input prio_t            win_prio,
    input logic [N_SRC-1:0] pend_q,
    input logic [N_SRC-1:0] en_q,
    input logic [N_SRC-1:0] rise
);
    // R6
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && act_valid) |-> (win_prio < act_prio));

    // R5
    offer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q[irq_num] && en_q[irq_num]));

    // R7
    enter_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_enter && irq_req && !core_exit) |=> (act_valid && act_prio == $past(win_prio)));

    // R7
    enter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_enter && irq_req && !core_exit && !rise[irq_num]) |=> !pend_q[$past(irq_num)]);

    // R7
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_enter && !irq_req && !core_exit) |=> ($stable(act_valid) && $stable(act_prio)));

    // R8
    exit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_exit && !act_valid) |=> !act_valid);
endmodule

bind nest_irq_ctrl nest_irq_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_enter(core_enter), .core_exit(core_exit),
    .irq_req(irq_req), .irq_num(irq_num), .act_valid(act_valid), .act_prio(act_prio),
    .win_prio(win_prio), .pend_q(pend_q), .en_q(en_q), .rise(rise)
);

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    localparam int N  = 40;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_wr = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          core_enter = 1'b0;
    logic          core_exit = 1'b0;
    logic          irq_req;
    logic [IW-1:0] irq_num;
    logic          act_valid;
    logic [2:0]    act_prio;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] en_sh [2];
    logic [31:0] pr_sh [10];

    always #2 clk = ~clk;

    nest_irq_ctrl #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .core_enter(core_enter), .core_exit(core_exit), .irq_req(irq_req),
        .irq_num(irq_num), .act_valid(act_valid), .act_prio(act_prio)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_prio(input int s, input logic [2:0] lvl);
        pr_sh[s/4][8*(s%4)+5 +: 3] = lvl;
        wr(5'(16 + s/4), pr_sh[s/4]);
    endtask

    task automatic enable(input int s);
        en_sh[s/32][s%32] = 1'b1;
        wr(5'(s/32), en_sh[s/32]);
    endtask

    task automatic fire(input logic [N-1:0] m);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic enter();
        core_enter = 1'b1;
        @(negedge clk);
        core_enter = 1'b0;
    endtask

    task automatic leave();
        core_exit = 1'b1;
        @(negedge clk);
        core_exit = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 act_valid", 32'(act_valid), 0);
        rd(5'd0, d);  chk("R1 enable word", d, 0);
        rd(5'd16, d); chk("R1 prio word", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(5'd16, 32'hFFFF_FFFF);
        rd(5'd16, d); chk("R2 prio masking", d, 32'hE0E0_E0E0);
        wr(5'd17, 32'h2A40_C07F);
        rd(5'd17, d); chk("R2 prio byte map", d, 32'h2040_C060);
        wr(5'd16, 32'h0); wr(5'd17, 32'h0);
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, d); chk("R3 unused enable bits", d, 32'h0000_00FF);
        wr(5'd1, 32'h0);
        wr(5'd5, 32'hFFFF_FFFF);
        rd(5'd5, d); chk("R3 unmapped address", d, 0);
    endtask

    task automatic t_disabled();
        set_prio(3, 3'd4);
        fire(N'(1) << 3);
        chk("R4 disabled not offered", 32'(irq_req), 0);
        enable(3);
        chk("R4 pending kept", 32'(irq_req), 1);
        chk("R4 num", 32'(irq_num), 3);
        enter();
        chk("R4 cleared on entry", 32'(irq_req), 0);
        leave();
        chk("R4 no re-offer", 32'(irq_req), 0);
    endtask

    task automatic t_arb();
        set_prio(5, 3'd4); set_prio(9, 3'd2); set_prio(12, 3'd2);
        enable(5); enable(9); enable(12);
        fire((N'(1) << 5) | (N'(1) << 9) | (N'(1) << 12));
        chk("R5 lowest value then index", 32'(irq_num), 9);
        enter();
        chk("R7 act_prio", 32'(act_prio), 2);
        chk("R6 equal level held", 32'(irq_req), 0);
        leave();
        chk("R10 tail chain req", 32'(irq_req), 1);
        chk("R10 tail chain num", 32'(irq_num), 12);
        enter(); leave();
        chk("R5 remaining num", 32'(irq_num), 5);
        enter(); leave();
        chk("R8 empty after drain", 32'(act_valid), 0);
    endtask

    task automatic t_nest();
        set_prio(20, 3'd5); set_prio(21, 3'd6); set_prio(22, 3'd1);
        enable(20); enable(21); enable(22);
        fire(N'(1) << 20); enter();
        fire(N'(1) << 21);
        chk("R6 lower level held", 32'(irq_req), 0);
        fire(N'(1) << 22);
        chk("R6 higher preempts", 32'(irq_req), 1);
        chk("R6 preempt num", 32'(irq_num), 22);
        enter();
        chk("R7 nested level", 32'(act_prio), 1);
        leave();
        chk("R8 restored level", 32'(act_prio), 5);
        chk("R8 still valid", 32'(act_valid), 1);
        chk("R10 held vs restored", 32'(irq_req), 0);
        leave();
        chk("R10 offered at thread", 32'(irq_num), 21);
        enter(); leave();
    endtask

    task automatic t_late();
        set_prio(30, 3'd6); set_prio(31, 3'd0);
        enable(30); enable(31);
        fire(N'(1) << 30);
        chk("R9 first offer", 32'(irq_num), 30);
        fire(N'(1) << 31);
        chk("R9 late arrival offer", 32'(irq_num), 31);
        enter();
        chk("R9 late arrival taken", 32'(act_prio), 0);
        leave();
        chk("R10 earlier one follows", 32'(irq_num), 30);
        enter(); leave();
    endtask

    task automatic t_ignored();
        enter();
        chk("R7 stray entry", 32'(act_valid), 0);
        leave();
        chk("R8 exit at empty", 32'(act_valid), 0);
        set_prio(33, 3'd3); set_prio(34, 3'd1);
        enable(33); enable(34);
        fire(N'(1) << 33); enter();
        fire(N'(1) << 34);
        core_enter = 1'b1; core_exit = 1'b1;
        @(negedge clk);
        core_enter = 1'b0; core_exit = 1'b0;
        chk("R11 exit wins", 32'(act_valid), 0);
        chk("R11 still pending", 32'(irq_num), 34);
        chk("R11 still offered", 32'(irq_req), 1);
        enter();
        chk("R11 later entry", 32'(act_prio), 1);
        leave();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        foreach (en_sh[i]) en_sh[i] = '0;
        foreach (pr_sh[i]) pr_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_arb();
        t_nest();
        t_late();
        t_ignored();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule